// File: doc/BRIEF.md
# Synchronous Dual-Port RAM with Per-Port Output Latency

This block is a two-port synchronous static memory in which both ports reach every word at the same time. Each port captures its address, write data and control lines on the rising clock edge. The controls are a pair of chip selects (one active low, one active high), a read/not-write line and an address-load enable. After that edge the port either stores a word or returns one. A static mode input on each port picks the read latency. In flow-through mode the word for the captured address is returned in the cycle right after the capture edge. In pipelined mode an extra output register delays it by one more edge. An output enable acts without the clock and blanks the port's data output at once. The off-chip three-state bus is shown as a data bus plus a drive-valid flag.

Both ports share one clock, so the same-address rule can be stated in cycles. A write captured at edge k reaches the array at edge k+1. A read of that word captured by the other port at edge k therefore returns the old value, and a read captured at edge k+1 returns the new one. When both ports write the same word on the same edge, port B's data is kept.

A pipelined port runs a small state machine with three states: PS_DESEL (deselected), PS_WAKE (one selected edge seen) and PS_LIVE (selected on two edges in a row). The transitions are:
- desel_to_wake: a select in PS_DESEL.
- wake_to_live: a select in PS_WAKE.
- live_hold: a select in PS_LIVE.
- any_to_desel: a missing select in any state.

In pipelined mode only reads captured in PS_LIVE reach the output. A read captured in PS_WAKE is the extra reactivation cycle. In flow-through mode the states have no effect. The default depth is kept small. Setting ADDR_W to 17 gives a 128K-word array.

Top module: `dual_port_ram`

## Requirements
- R1: On a synchronous reset, both ports' rvalid go low and their rdata go to zero, and a pipelined port returns to PS_DESEL.
- R2: A port is selected only when cs_n is 0 and cs is 1 at the rising edge. A command captured while the port is not selected writes nothing and leaves that port's rvalid low in the command's output cycle.
- R3: A selected command with rnw = 0 stores wdata at the captured address. Both ports see the stored word on later reads.
- R4: With pipe = 0, a selected read (rnw = 1) captured at edge k drives rvalid = 1 and rdata = the addressed word from just after edge k until edge k+1.
- R5: With pipe = 1, the same read shows one edge later, from edge k+1 to edge k+2. Each port's mode is independent of the other port's.
- R6: oe_n = 1 forces rvalid to 0 and rdata to 0 at once, with no clock edge. Taking oe_n back to 0 restores the pending output within the same cycle.
- R7: With pipe = 1, a read captured in the first selected edge after a deselect (PS_WAKE) produces no output. Reads captured in PS_LIVE do.
- R8: When addr_ld = 0 at an edge, the port keeps its previous address. With no write to that word, the port's output stays the same on each following cycle.
- R9: Suppose one port writes word X at edge k and the other port reads X at edge k. The read returns the old contents of X, and a read of X captured at edge k+1 returns the new data.
- R10: When both ports write the same word at the same edge, the word keeps port B's data.
- R11: A write command never drives the port's output: rvalid stays 0 in the output cycle that belongs to a write.
- R12: Whenever rvalid is 0, rdata is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| a_cs_n | input | 1 | Port A select, active low |
| a_cs | input | 1 | Port A select, active high |
| a_rnw | input | 1 | Port A read (1) or write (0) |
| a_oe_n | input | 1 | Port A output enable, active low, asynchronous |
| a_pipe | input | 1 | Port A mode: 0 flow-through, 1 pipelined (static) |
| a_addr_ld | input | 1 | Port A address load; 0 holds the previous address |
| a_addr | input | ADDR_W | Port A word address |
| a_wdata | input | DATA_W | Port A write data |
| a_rdata | output | DATA_W | Port A read data, zero when not driven |
| a_rvalid | output | 1 | Port A drive enable for rdata |
| b_cs_n | input | 1 | Port B select, active low |
| b_cs | input | 1 | Port B select, active high |
| b_rnw | input | 1 | Port B read (1) or write (0) |
| b_oe_n | input | 1 | Port B output enable, active low, asynchronous |
| b_pipe | input | 1 | Port B mode: 0 flow-through, 1 pipelined (static) |
| b_addr_ld | input | 1 | Port B address load; 0 holds the previous address |
| b_addr | input | ADDR_W | Port B word address |
| b_wdata | input | DATA_W | Port B write data |
| b_rdata | output | DATA_W | Port B read data, zero when not driven |
| b_rvalid | output | 1 | Port B drive enable for rdata |

## Verification
The bench builds the block with ADDR_W = 5 and DATA_W = 8, so the whole 32-word array can be filled and read back through both ports in a few hundred cycles. The small space also makes random traffic hit the same word from both ports often, which exercises the same-edge write/write and write/read rules. The bench first runs with port A flow-through and port B pipelined, then swaps the modes under reset. This covers both latencies on each port and the PS_WAKE reactivation cycle after every random deselect.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

    // Pipelined-port reactivation states
    typedef enum logic [1:0] {
        PS_DESEL = 2'd0,
        PS_WAKE  = 2'd1,
        PS_LIVE  = 2'd2
    } port_state_t;

    localparam int NUM_PORTS = 2;

endpackage

// File: rtl/dpr_port_front.sv
module dpr_port_front
    import dpr_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              cs,
    input  logic              rnw,
    input  logic              addr_ld,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              rd_q,
    output logic              wr_q,
    output logic              live,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q
);

    logic        sel;
    port_state_t state_q;
    port_state_t state_d;

    assign sel = !cs_n && cs;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PS_DESEL;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_DESEL: if (sel) state_d = PS_WAKE;
            PS_WAKE:  state_d = sel ? PS_LIVE : PS_DESEL;
            PS_LIVE:  if (!sel) state_d = PS_DESEL;
            default:  state_d = PS_DESEL;
        endcase
    end

    // Outputs derived from state
    always_comb begin
        live = (state_q == PS_LIVE);
    end

    // Captured command
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= 1'b0;
            wr_q <= 1'b0;
        end else begin
            rd_q <= sel && rnw;
            wr_q <= sel && !rnw;
        end
    end

    // Captured address and data
    always_ff @(posedge clk) begin
        if (addr_ld) begin
            addr_q <= addr;
        end
        wdata_q <= wdata;
    end

endmodule

// File: rtl/dpr_array.sv
module dpr_array
    import dpr_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic                              clk,
    input  logic [NUM_PORTS-1:0]              wr_en,
    input  logic [NUM_PORTS-1:0][ADDR_W-1:0]  addr,
    input  logic [NUM_PORTS-1:0][DATA_W-1:0]  wdata,
    output logic [NUM_PORTS-1:0][DATA_W-1:0]  rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Writes land one edge after capture; the higher port index wins a tie
    always_ff @(posedge clk) begin
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (wr_en[p]) begin
                mem[addr[p]] <= wdata[p];
            end
        end
    end

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_rd
        assign rdata[g] = mem[addr[g]];
    end

endmodule

// File: rtl/dpr_out_stage.sv
module dpr_out_stage #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pipe,
    input  logic              oe_n,
    input  logic              rd_q,
    input  logic              live,
    input  logic [DATA_W-1:0] arr_data,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);

    logic              pvld_q;
    logic [DATA_W-1:0] pdata_q;
    logic              core_v;
    logic [DATA_W-1:0] core_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            pvld_q <= 1'b0;
        end else begin
            pvld_q <= rd_q && live;
        end
    end

    always_ff @(posedge clk) begin
        pdata_q <= arr_data;
    end

    always_comb begin
        core_v = pipe ? pvld_q : rd_q;
        core_d = pipe ? pdata_q : arr_data;
        rvalid = core_v && !oe_n;
        rdata  = rvalid ? core_d : '0;
    end

endmodule

// File: rtl/dual_port_ram.sv
module dual_port_ram
    import dpr_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              a_cs_n,
    input  logic              a_cs,
    input  logic              a_rnw,
    input  logic              a_oe_n,
    input  logic              a_pipe,
    input  logic              a_addr_ld,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    output logic              a_rvalid,
    input  logic              b_cs_n,
    input  logic              b_cs,
    input  logic              b_rnw,
    input  logic              b_oe_n,
    input  logic              b_pipe,
    input  logic              b_addr_ld,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata,
    output logic              b_rvalid
);

    logic [NUM_PORTS-1:0]             cs_n_v, cs_v, rnw_v, oe_n_v, pipe_v, ld_v;
    logic [NUM_PORTS-1:0][ADDR_W-1:0] addr_v, addr_q_v;
    logic [NUM_PORTS-1:0][DATA_W-1:0] wdata_v, wdata_q_v, arr_v, rdata_v;
    logic [NUM_PORTS-1:0]             rd_q_v, wr_q_v, live_v, rvalid_v;

    assign cs_n_v  = {b_cs_n,    a_cs_n};
    assign cs_v    = {b_cs,      a_cs};
    assign rnw_v   = {b_rnw,     a_rnw};
    assign oe_n_v  = {b_oe_n,    a_oe_n};
    assign pipe_v  = {b_pipe,    a_pipe};
    assign ld_v    = {b_addr_ld, a_addr_ld};
    assign addr_v  = {b_addr,    a_addr};
    assign wdata_v = {b_wdata,   a_wdata};

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
        dpr_port_front #(
            .ADDR_W (ADDR_W),
            .DATA_W (DATA_W)
        ) u_front (
            .clk     (clk),
            .rst     (rst),
            .cs_n    (cs_n_v[g]),
            .cs      (cs_v[g]),
            .rnw     (rnw_v[g]),
            .addr_ld (ld_v[g]),
            .addr    (addr_v[g]),
            .wdata   (wdata_v[g]),
            .rd_q    (rd_q_v[g]),
            .wr_q    (wr_q_v[g]),
            .live    (live_v[g]),
            .addr_q  (addr_q_v[g]),
            .wdata_q (wdata_q_v[g])
        );

        dpr_out_stage #(
            .DATA_W (DATA_W)
        ) u_out (
            .clk      (clk),
            .rst      (rst),
            .pipe     (pipe_v[g]),
            .oe_n     (oe_n_v[g]),
            .rd_q     (rd_q_v[g]),
            .live     (live_v[g]),
            .arr_data (arr_v[g]),
            .rdata    (rdata_v[g]),
            .rvalid   (rvalid_v[g])
        );
    end

    dpr_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_array (
        .clk   (clk),
        .wr_en (wr_q_v),
        .addr  (addr_q_v),
        .wdata (wdata_q_v),
        .rdata (arr_v)
    );

    assign a_rdata  = rdata_v[0];
    assign a_rvalid = rvalid_v[0];
    assign b_rdata  = rdata_v[1];
    assign b_rvalid = rvalid_v[1];

endmodule

// File: rtl/dpr_checker.sv
module dpr_checker (
    input logic clk,
    input logic rst,
    input logic a_cs_n,
    input logic a_cs,
    input logic a_rnw,
    input logic a_oe_n,
    input logic a_pipe,
    input logic a_rvalid,
    input logic b_cs_n,
    input logic b_cs,
    input logic b_rnw,
    input logic b_oe_n,
    input logic b_pipe,
    input logic b_rvalid
);

    logic sel_a, sel_b;
    logic rst_d;
    logic armed_q;

    assign sel_a = !a_cs_n && a_cs;
    assign sel_b = !b_cs_n && b_cs;

    always_ff @(posedge clk) begin
        rst_d   <= rst;
        armed_q <= !rst;
    end

    // R1: outputs quiet in the cycle after a reset edge
    always @(negedge clk) begin
        if (rst_d === 1'b1) begin
            p_reset_quiet_r1: assert (!a_rvalid && !b_rvalid);
        end
    end

    // R6: output enable high means no drive
    p_oe_off_a_r6: assert property (@(posedge clk) disable iff (rst)
        a_oe_n |-> !a_rvalid);
    p_oe_off_b_r6: assert property (@(posedge clk) disable iff (rst)
        b_oe_n |-> !b_rvalid);

    // R2: deselected command gives no output (flow-through)
    p_desel_ft_a_r2: assert property (@(posedge clk) disable iff (rst)
        (!a_pipe && !sel_a) |=> !a_rvalid);
    p_desel_ft_b_r2: assert property (@(posedge clk) disable iff (rst)
        (!b_pipe && !sel_b) |=> !b_rvalid);

    // R2: deselected command gives no output (pipelined)
    p_desel_pp_a_r2: assert property (@(posedge clk) disable iff (rst)
        (a_pipe && !sel_a) |=> ##1 !a_rvalid);
    p_desel_pp_b_r2: assert property (@(posedge clk) disable iff (rst)
        (b_pipe && !sel_b) |=> ##1 !b_rvalid);

    // R11: write commands never drive
    p_write_quiet_a_r11: assert property (@(posedge clk) disable iff (rst)
        (!a_pipe && sel_a && !a_rnw) |=> !a_rvalid);
    p_write_quiet_b_r11: assert property (@(posedge clk) disable iff (rst)
        (b_pipe && sel_b && !b_rnw) |=> ##1 !b_rvalid);

    // R7: first selected edge after a deselect yields no pipelined output
    p_wake_a_r7: assert property (@(posedge clk) disable iff (rst)
        (armed_q && a_pipe && sel_a && !$past(sel_a)) |=> ##1 !a_rvalid);
    p_wake_b_r7: assert property (@(posedge clk) disable iff (rst)
        (armed_q && b_pipe && sel_b && !$past(sel_b)) |=> ##1 !b_rvalid);

endmodule

bind dual_port_ram dpr_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .a_cs_n   (a_cs_n),
    .a_cs     (a_cs),
    .a_rnw    (a_rnw),
    .a_oe_n   (a_oe_n),
    .a_pipe   (a_pipe),
    .a_rvalid (a_rvalid),
    .b_cs_n   (b_cs_n),
    .b_cs     (b_cs),
    .b_rnw    (b_rnw),
    .b_oe_n   (b_oe_n),
    .b_pipe   (b_pipe),
    .b_rvalid (b_rvalid)
);

// File: tb/dual_port_ram_test.sv
`timescale 1ns/1ps
module dual_port_ram_test;

    localparam int AW    = 5;
    localparam int DW    = 8;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic a_cs_n, a_cs, a_rnw, a_oe_n, a_pipe, a_addr_ld;
    logic b_cs_n, b_cs, b_rnw, b_oe_n, b_pipe, b_addr_ld;
    logic [AW-1:0] a_addr, b_addr;
    logic [DW-1:0] a_wdata, b_wdata, a_rdata, b_rdata;
    logic a_rvalid, b_rvalid;

    always #2.5 clk = ~clk;

    dual_port_ram #(.ADDR_W(AW), .DATA_W(DW)) uut (
        .clk(clk), .rst(rst),
        .a_cs_n(a_cs_n), .a_cs(a_cs), .a_rnw(a_rnw), .a_oe_n(a_oe_n),
        .a_pipe(a_pipe), .a_addr_ld(a_addr_ld), .a_addr(a_addr),
        .a_wdata(a_wdata), .a_rdata(a_rdata), .a_rvalid(a_rvalid),
        .b_cs_n(b_cs_n), .b_cs(b_cs), .b_rnw(b_rnw), .b_oe_n(b_oe_n),
        .b_pipe(b_pipe), .b_addr_ld(b_addr_ld), .b_addr(b_addr),
        .b_wdata(b_wdata), .b_rdata(b_rdata), .b_rvalid(b_rvalid)
    );

    int    n_tests = 0;
    int    n_fail  = 0;
    string cur_req = "R1";

    // Behavioural reference model
    logic [DW-1:0] m_mem [DEPTH];
    logic [AW-1:0] m_aq  [2];
    logic [DW-1:0] m_wd  [2];
    logic [DW-1:0] m_pd  [2];
    bit m_rd [2], m_wr [2], m_prev [2], m_rdlive [2], m_pv [2];

    always @(posedge clk) begin
        bit            sel [2];
        bit            rnw [2];
        bit            ld  [2];
        logic [AW-1:0] ad  [2];
        logic [DW-1:0] wd  [2];
        sel[0] = !a_cs_n && a_cs; sel[1] = !b_cs_n && b_cs;
        rnw[0] = a_rnw;  rnw[1] = b_rnw;
        ld[0]  = a_addr_ld; ld[1] = b_addr_ld;
        ad[0]  = a_addr; ad[1] = b_addr;
        wd[0]  = a_wdata; wd[1] = b_wdata;
        if (rst) begin
            for (int p = 0; p < 2; p++) begin
                m_rd[p] = 0; m_wr[p] = 0; m_prev[p] = 0;
                m_rdlive[p] = 0; m_pv[p] = 0;
            end
        end else begin
            for (int p = 0; p < 2; p++) begin
                m_pv[p] = m_rdlive[p];
                m_pd[p] = m_mem[m_aq[p]];
            end
            for (int p = 0; p < 2; p++)
                if (m_wr[p]) m_mem[m_aq[p]] = m_wd[p];
            for (int p = 0; p < 2; p++) begin
                m_rdlive[p] = sel[p] && rnw[p] && m_prev[p];
                m_rd[p]     = sel[p] && rnw[p];
                m_wr[p]     = sel[p] && !rnw[p];
                m_prev[p]   = sel[p];
            end
        end
        for (int p = 0; p < 2; p++) begin
            if (ld[p]) m_aq[p] = ad[p];
            m_wd[p] = wd[p];
        end
    end

    function automatic logic [DW-1:0] pat(int i);
        return DW'((i * 37 + 11) & 255);
    endfunction

    task automatic check_port(int p);
        logic ev, av, pipe, oen;
        logic [DW-1:0] ed, ad;
        pipe = (p == 0) ? a_pipe : b_pipe;
        oen  = (p == 0) ? a_oe_n : b_oe_n;
        av   = (p == 0) ? a_rvalid : b_rvalid;
        ad   = (p == 0) ? a_rdata : b_rdata;
        ev   = (pipe ? m_pv[p] : m_rd[p]) && !oen;
        ed   = ev ? (pipe ? m_pd[p] : m_mem[m_aq[p]]) : '0;  // R12
        n_tests++;
        if (av !== ev || ad !== ed) begin
            n_fail++;
            $display("FAIL %s port %0d: rvalid=%b rdata=%h expected rvalid=%b rdata=%h",
                     cur_req, p, av, ad, ev, ed);
        end
    endtask

    task automatic expect_eq(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
        check_port(0);
        check_port(1);
    endtask

    task automatic raw(int p, bit csn, bit cs, bit rnw, bit ld, int addr, int wd);
        if (p == 0) begin
            a_cs_n = csn; a_cs = cs; a_rnw = rnw; a_addr_ld = ld;
            a_addr = addr[AW-1:0]; a_wdata = wd[DW-1:0];
        end else begin
            b_cs_n = csn; b_cs = cs; b_rnw = rnw; b_addr_ld = ld;
            b_addr = addr[AW-1:0]; b_wdata = wd[DW-1:0];
        end
    endtask

    task automatic wr(int p, int addr, int wd); raw(p, 0, 1, 0, 1, addr, wd); endtask
    task automatic rd(int p, int addr);         raw(p, 0, 1, 1, 1, addr, 0);  endtask
    task automatic idle(int p);                 raw(p, 1, 0, 1, 1, 0, 0);     endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        finish_run();
    end

    task automatic random_phase(int n);
        for (int k = 0; k < n; k++) begin
            for (int p = 0; p < 2; p++)
                raw(p, ($urandom % 4) == 0, ($urandom % 5) != 0, $urandom % 2,
                    ($urandom % 6) != 0, $urandom % DEPTH, $urandom % 256);
            a_oe_n = ($urandom % 7) == 0;
            b_oe_n = ($urandom % 7) == 0;
            cyc();
        end
        a_oe_n = 0; b_oe_n = 0;
    endtask

    initial begin
        a_pipe = 0; b_pipe = 1; a_oe_n = 0; b_oe_n = 0;
        idle(0); idle(1);
        rst = 1;
        cur_req = "R1";
        repeat (3) cyc();
        expect_eq("R1", {31'b0, a_rvalid}, 0);
        expect_eq("R1", {31'b0, b_rvalid}, 0);
        expect_eq("R1", {24'b0, a_rdata | b_rdata}, 0);
        rst = 0;

        // R3 fill through port A, R11 write produces no drive
        cur_req = "R3";
        for (int i = 0; i < DEPTH; i++) begin
            wr(0, i, pat(i));
            cyc();
            expect_eq("R11", {31'b0, a_rvalid}, 0);
        end

        // R4 flow-through on A, R5 pipelined on B, R7 wake cycle
        cur_req = "R4";
        for (int i = 0; i < DEPTH; i++) begin
            rd(0, i);
            rd(1, DEPTH - 1 - i);
            cyc();
            expect_eq("R4", {24'b0, a_rdata}, {24'b0, pat(i)});
            if (i == 1) expect_eq("R7", {31'b0, b_rvalid}, 0);
            if (i >= 2) expect_eq("R5", {24'b0, b_rdata}, {24'b0, pat(DEPTH - i)});
        end
        idle(0); idle(1);
        cyc();

        // R2 selection rule
        cur_req = "R2";
        raw(0, 1, 1, 0, 1, 3, 8'h5A); cyc();
        raw(0, 0, 0, 0, 1, 4, 8'hA5); cyc();
        raw(0, 1, 1, 1, 1, 3, 0);     cyc();
        expect_eq("R2", {31'b0, a_rvalid}, 0);
        rd(0, 3); cyc();
        expect_eq("R2", {24'b0, a_rdata}, {24'b0, pat(3)});
        rd(0, 4); cyc();
        expect_eq("R2", {24'b0, a_rdata}, {24'b0, pat(4)});

        // R6 asynchronous output enable
        cur_req = "R6";
        rd(0, 7); cyc();
        a_oe_n = 1; #1; check_port(0);
        expect_eq("R6", {31'b0, a_rvalid}, 0);
        expect_eq("R6", {24'b0, a_rdata}, 0);
        a_oe_n = 0; #1; check_port(0);
        expect_eq("R6", {24'b0, a_rdata}, {24'b0, pat(7)});

        // R8 address hold on both modes
        cur_req = "R8";
        rd(0, 10); rd(1, 11); cyc();
        rd(1, 11); cyc();
        for (int k = 0; k < 3; k++) begin
            raw(0, 0, 1, 1, 0, 20, 0);
            raw(1, 0, 1, 1, 0, 21, 0);
            cyc();
            expect_eq("R8", {24'b0, a_rdata}, {24'b0, pat(10)});
            expect_eq("R8", {24'b0, b_rdata}, {24'b0, pat(11)});
        end
        idle(1);

        // R9 same-address write on B, read on A in the same edge
        cur_req = "R9";
        rd(0, 5); wr(1, 5, 8'hC3); cyc();
        expect_eq("R9", {24'b0, a_rdata}, {24'b0, pat(5)});
        rd(0, 5); idle(1); cyc();
        expect_eq("R9", {24'b0, a_rdata}, 32'hC3);

        // R10 simultaneous writes, B kept
        cur_req = "R10";
        wr(0, 9, 8'h11); wr(1, 9, 8'h22); cyc();
        rd(0, 9); idle(1); cyc();
        expect_eq("R10", {24'b0, a_rdata}, 32'h22);

        // R11 write cycle in pipelined mode does not drive
        cur_req = "R11";
        idle(0);
        rd(1, 13); cyc();
        rd(1, 13); cyc();
        wr(1, 14, 8'h44); cyc();
        expect_eq("R11", {24'b0, b_rdata}, {24'b0, pat(13)});
        idle(1); cyc();
        expect_eq("R11", {31'b0, b_rvalid}, 0);

        // Mixed random traffic, A flow-through and B pipelined
        cur_req = "R3";
        random_phase(400);

        // Swap modes under reset
        cur_req = "R1";
        rst = 1; idle(0); idle(1);
        cyc();
        a_pipe = 1; b_pipe = 0;
        cyc();
        rst = 0;
        cur_req = "R5";
        random_phase(400);

        idle(0); idle(1);
        repeat (3) cyc();
        finish_run();
    end

endmodule